// File: doc/BRIEF.md
# Four-Unit Execute Stage with Status Flags

This block is the execute stage of a small 8-bit processor. It has no clock in its data path. A select code picks one of four processing units, and that unit's output drives the result bus. The four units are an adder/subtractor, a right shifter, a memory/IO access path and a passthrough. One operand reaches the stage over the shared source bus. The other comes straight from the temporary register through a dedicated connection. That temporary value is both the first adder operand and the memory/IO address.

Three status bits sit next to the stage and are the only clocked state: negative, zero and carry. They are not connected to any bus. The adder and shifter feed them through direct wires, and they update on a clock edge only when the flag-write enable is high. The stored carry goes back into the adder for add-with-carry and subtract-with-borrow, and into the shifter for rotate-through-carry.

An external controller drives the select and mode inputs each cycle. It also performs the write of the result bus into the register file.

Top module: `proc_exec_stage`

## Requirements
- R1: `unit_sel` picks the unit that drives `result_bus`. The codes are 2'b00 adder, 2'b01 shifter, 2'b10 memory/IO and 2'b11 passthrough.
- R2: With the adder selected and `sub`=0, `result_bus` = `tmp_reg` + `src_bus` + cin, taken modulo 256. cin is the stored carry when `use_carry`=1 and 0 otherwise. The carry out of bit 7 is the new carry.
- R3: With the adder selected and `sub`=1, `result_bus` = `tmp_reg` + ~`src_bus` + cin. cin is the stored carry when `use_carry`=1 and 1 otherwise. The new carry is 1 when no borrow occurs.
- R4: With the shifter selected and `use_carry`=0, `result_bus` is `src_bus` shifted right by one with 0 entering bit 7. The old bit 0 becomes the new carry.
- R5: With the shifter selected and `use_carry`=1, the stored carry enters bit 7 and the old bit 0 becomes the new carry.
- R6: When `flag_we`=1 and the adder or shifter is selected, the next rising edge loads the flags as follows. `flag_n` becomes bit 7 of the result. `flag_z` becomes 1 exactly when all 8 result bits are 0. `flag_c` becomes the unit's carry.
- R7: When `flag_we`=0, all three flags keep their values across the edge.
- R8: When the memory/IO unit or the passthrough is selected, the flags keep their values even if `flag_we`=1.
- R9: `mem_addr` always equals `tmp_reg`. `mem_wdata` always equals `src_bus`. With the memory/IO unit selected, `result_bus` = `mem_rdata`. `mem_we` is 1 exactly when the memory/IO unit is selected and `mem_store`=1.
- R10: With the passthrough selected, `result_bus` equals `src_bus` unchanged.
- R11: While `rst_n` is low, all three flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_sel | input | 2 | Processing unit select |
| sub | input | 1 | Adder subtracts when 1 |
| use_carry | input | 1 | Use stored carry (add/sub with carry, rotate) |
| mem_store | input | 1 | Memory/IO access is a write |
| flag_we | input | 1 | Flag write enable |
| src_bus | input | 8 | Source bus operand |
| tmp_reg | input | 8 | Temporary register operand / address |
| mem_rdata | input | 8 | Memory/IO read data |
| result_bus | output | 8 | Selected unit result |
| mem_addr | output | 8 | Memory/IO address |
| mem_wdata | output | 8 | Memory/IO write data |
| mem_we | output | 1 | Memory/IO write strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench targets carry handling in four places. An add that wraps to zero must set both Z and C. A subtraction that borrows must clear C, and one that does not borrow must set it. A design that used the borrow polarity the wrong way round would get these backwards. The with-carry forms must consume the stored C, so a design that ignored it would be off by one, or off by bit 7 for rotates. The bench also sets up known flags and then runs passthrough and memory operations with the write enable high, and separately issues adder operations with the enable low. A design that gated the flags incorrectly would change them in those cases. Store strobes are checked in both directions, because a strobe that fired on loads would corrupt memory.

// File: rtl/exec_stage_pkg.sv
package exec_stage_pkg;
    // Unit select encoding shared by the stage and its checker
    typedef enum logic [1:0] {
        UNIT_ADD   = 2'b00,
        UNIT_SHIFT = 2'b01,
        UNIT_MEM   = 2'b10,
        UNIT_PASS  = 2'b11
    } unit_sel_e;

    localparam int DATA_W = 8;
endpackage

// File: rtl/exec_adder.sv
// exec_adder: one adder that handles both add and subtract.
// Assumes op_a comes from the temporary register and op_b from the source bus.
// Subtraction inverts op_b. Carry-in is the stored carry when use_carry is set,
// and otherwise equals sub (0 for add, 1 for subtract).
module exec_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub,
    input  logic         use_carry,
    input  logic         c_stored,
    output logic [W-1:0] sum,
    output logic         c_out
);
    logic [W-1:0] b_eff;
    logic         c_in;
    logic [W:0]   wide;

    // Form the effective operand and carry-in, then add with one extra bit
    always_comb begin
        b_eff = sub ? ~op_b : op_b;
        c_in  = use_carry ? c_stored : sub;
        wide  = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, c_in};
        sum   = wide[W-1:0];
        c_out = wide[W];
    end
endmodule

// File: rtl/exec_shifter.sv
// exec_shifter: shifts right by one bit.
// rotate=0 shifts a zero into the MSB. rotate=1 shifts the stored carry in.
// The LSB that falls out becomes the carry out in both modes.
module exec_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_in,
    input  logic         rotate,
    input  logic         c_stored,
    output logic [W-1:0] data_out,
    output logic         c_out
);
    // Choose the bit entering the MSB and capture the bit leaving the LSB
    always_comb begin
        data_out = {(rotate ? c_stored : 1'b0), data_in[W-1:1]};
        c_out    = data_in[0];
    end
endmodule

// File: rtl/exec_memio.sv
// exec_memio: the memory/IO access path.
// The address always comes from the temporary register and the write data from
// the source bus. The strobe is raised only for a selected store. Read data is
// returned as this unit's result. The memory itself is outside the block.
module exec_memio #(
    parameter int W = 8
) (
    input  logic         selected,
    input  logic         store,
    input  logic [W-1:0] addr_src,
    input  logic [W-1:0] wdata_src,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] addr,
    output logic [W-1:0] wdata,
    output logic         we,
    output logic [W-1:0] load_result
);
    // Drive the address, data and strobe toward memory, and return the read data
    always_comb begin
        addr        = addr_src;
        wdata       = wdata_src;
        we          = selected & store;
        load_result = rdata;
    end
endmodule

// File: rtl/exec_flags.sv
// exec_flags: the three-bit status register (negative, zero, carry).
// It is loaded from the adder or shifter result through direct wires and never
// from a bus. Uses a synchronous active-low reset that clears all bits.
module exec_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] res,
    input  logic         c_new,
    output logic         n_q,
    output logic         z_q,
    output logic         c_q
);
    // Clear on reset, otherwise load N/Z/C when load is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (load) begin
            n_q <= res[W-1];
            z_q <= (res == '0);
            c_q <= c_new;
        end
    end
endmodule

// File: rtl/proc_exec_stage.sv
// proc_exec_stage: combinational execute stage with four selectable units and
// an attached status register. Assumes the controller keeps its select and mode
// inputs stable for the whole cycle, and writes result_bus into the register
// file itself.
module proc_exec_stage
    import exec_stage_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   unit_sel,
    input  logic         sub,
    input  logic         use_carry,
    input  logic         mem_store,
    input  logic         flag_we,
    input  logic [W-1:0] src_bus,
    input  logic [W-1:0] tmp_reg,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] result_bus,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c
);
    unit_sel_e    sel;
    logic [W-1:0] add_res;
    logic         add_c;
    logic [W-1:0] shf_res;
    logic         shf_c;
    logic [W-1:0] mem_res;
    logic         flag_load;
    logic         c_next;

    // Decode the raw select into the shared enum
    always_comb sel = unit_sel_e'(unit_sel);

    exec_adder #(.W(W)) adder_i (
        .op_a      (tmp_reg),
        .op_b      (src_bus),
        .sub       (sub),
        .use_carry (use_carry),
        .c_stored  (flag_c),
        .sum       (add_res),
        .c_out     (add_c)
    );

    exec_shifter #(.W(W)) shifter_i (
        .data_in  (src_bus),
        .rotate   (use_carry),
        .c_stored (flag_c),
        .data_out (shf_res),
        .c_out    (shf_c)
    );

    exec_memio #(.W(W)) memio_i (
        .selected    (sel == UNIT_MEM),
        .store       (mem_store),
        .addr_src    (tmp_reg),
        .wdata_src   (src_bus),
        .rdata       (mem_rdata),
        .addr        (mem_addr),
        .wdata       (mem_wdata),
        .we          (mem_we),
        .load_result (mem_res)
    );

    // Route the selected unit to the result bus
    always_comb begin
        unique case (sel)
            UNIT_ADD:   result_bus = add_res;
            UNIT_SHIFT: result_bus = shf_res;
            UNIT_MEM:   result_bus = mem_res;
            default:    result_bus = src_bus;
        endcase
    end

    // Allow a flag load only for the adder and shifter, and pick that unit's carry
    always_comb begin
        flag_load = flag_we && (sel == UNIT_ADD || sel == UNIT_SHIFT);
        c_next    = (sel == UNIT_SHIFT) ? shf_c : add_c;
    end

    exec_flags #(.W(W)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .res   (result_bus),
        .c_new (c_next),
        .n_q   (flag_n),
        .z_q   (flag_z),
        .c_q   (flag_c)
    );
endmodule

// File: rtl/exec_stage_checks.sv
// exec_stage_checks: port-level properties for proc_exec_stage, bound to every
// instance of that module.
module exec_stage_checks
    import exec_stage_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   unit_sel,
    input logic         sub,
    input logic         use_carry,
    input logic         mem_store,
    input logic         flag_we,
    input logic [W-1:0] src_bus,
    input logic [W-1:0] tmp_reg,
    input logic [W-1:0] mem_rdata,
    input logic [W-1:0] result_bus,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata,
    input logic         mem_we,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c
);
    // R2: a plain add returns the modular sum of the operands
    assert_plain_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_ADD && !sub && !use_carry) |-> result_bus == W'(tmp_reg + src_bus));

    // R4/R5: the shifter moves the bus right by one bit
    assert_shift_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_SHIFT) |-> result_bus[W-2:0] == src_bus[W-1:1]);

    assert_rotate_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_SHIFT && use_carry) |-> result_bus[W-1] == flag_c);

    // R6: N and Z follow the result that was loaded
    assert_nz_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && (unit_sel == UNIT_ADD || unit_sel == UNIT_SHIFT)) |=>
        (flag_n == $past(result_bus[W-1]) && flag_z == ($past(result_bus) == '0)));

    // R7: the flags hold when the write enable is low
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable({flag_n, flag_z, flag_c}));

    // R8: memory and passthrough operations leave the flags unchanged
    assert_flags_off_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_MEM || unit_sel == UNIT_PASS) |=> $stable({flag_n, flag_z, flag_c}));

    // R9: memory path wiring and strobe gating
    assert_mem_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr == tmp_reg && mem_wdata == src_bus
        && mem_we == (unit_sel == UNIT_MEM && mem_store)
        && (unit_sel != UNIT_MEM || result_bus == mem_rdata));

    // R10: passthrough does not alter the bus value
    assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == UNIT_PASS) |-> result_bus == src_bus);

    // R11: the edge after a reset cycle leaves all flags clear
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !(flag_n || flag_z || flag_c));
endmodule

bind proc_exec_stage exec_stage_checks #(.W(W)) chk_i (.*);

// File: tb/proc_exec_stage_tb_top.sv
module proc_exec_stage_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] unit_sel;
    logic       sub, use_carry, mem_store, flag_we;
    logic [7:0] src_bus, tmp_reg, mem_rdata;
    logic [7:0] result_bus, mem_addr, mem_wdata;
    logic       mem_we, flag_n, flag_z, flag_c;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] m_flags;   // bench model of {N,Z,C}

    always #(CLK_PERIOD/2) clk = ~clk;

    proc_exec_stage dut_i (
        .clk(clk), .rst_n(rst_n), .unit_sel(unit_sel), .sub(sub),
        .use_carry(use_carry), .mem_store(mem_store), .flag_we(flag_we),
        .src_bus(src_bus), .tmp_reg(tmp_reg), .mem_rdata(mem_rdata),
        .result_bus(result_bus), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Apply one operation at the falling edge, check the combinational outputs,
    // then check the flags after the next rising edge
    task automatic run_op(string req, logic [1:0] s, logic sb, logic uc, logic st,
                          logic we, logic [7:0] bus, logic [7:0] t, logic [7:0] rd);
        logic [8:0] wide;
        logic [7:0] exp_res;
        logic       exp_c;
        logic       cin;
        @(negedge clk);
        unit_sel = s; sub = sb; use_carry = uc; mem_store = st; flag_we = we;
        src_bus = bus; tmp_reg = t; mem_rdata = rd;
        exp_c = m_flags[0];
        case (s)
            2'b00: begin
                cin     = uc ? m_flags[0] : sb;
                wide    = {1'b0, t} + {1'b0, (sb ? ~bus : bus)} + {8'd0, cin};
                exp_res = wide[7:0];
                exp_c   = wide[8];
            end
            2'b01: begin
                exp_res = {(uc ? m_flags[0] : 1'b0), bus[7:1]};
                exp_c   = bus[0];
            end
            2'b10:   exp_res = rd;
            default: exp_res = bus;
        endcase
        #1;
        check(req, "result_bus", result_bus, exp_res);
        check("R9", "mem_addr", mem_addr, t);
        check("R9", "mem_wdata", mem_wdata, bus);
        check("R9", "mem_we", {7'd0, mem_we}, {7'd0, (s == 2'b10) && st});
        if (we && (s == 2'b00 || s == 2'b01))
            m_flags = {exp_res[7], exp_res == 8'd0, exp_c};
        @(posedge clk);
        #1;
        check(req, "flags NZC", {5'd0, flag_n, flag_z, flag_c}, {5'd0, m_flags});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        unit_sel = 2'b00; sub = 0; use_carry = 0; mem_store = 0; flag_we = 1;
        src_bus = 8'hFF; tmp_reg = 8'h01; mem_rdata = 8'h00;
        repeat (2) @(posedge clk);
        #1;
        m_flags = 3'b000;
        check("R11", "flags in reset", {5'd0, flag_n, flag_z, flag_c}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op("R2", 2'b00, 0, 0, 0, 1, 8'h20, 8'h10, 8'h00);   // 0x30, no carry
        run_op("R2", 2'b00, 0, 0, 0, 1, 8'h20, 8'hF0, 8'h00);   // wraps, C=1
        run_op("R6", 2'b00, 0, 0, 0, 1, 8'h80, 8'h80, 8'h00);   // zero, C=1
        run_op("R2", 2'b00, 0, 1, 0, 1, 8'h01, 8'h01, 8'h00);   // add with C=1 -> 3
        run_op("R6", 2'b00, 0, 0, 0, 1, 8'h01, 8'h7F, 8'h00);   // 0x80, N=1
    endtask

    task automatic t_sub();
        run_op("R3", 2'b00, 1, 0, 0, 1, 8'h10, 8'h30, 8'h00);   // 0x20, C=1
        run_op("R3", 2'b00, 1, 0, 0, 1, 8'h30, 8'h10, 8'h00);   // 0xE0, borrow C=0
        run_op("R3", 2'b00, 1, 1, 0, 1, 8'h05, 8'h09, 8'h00);   // C=0: 9-5-1 = 3
        run_op("R3", 2'b00, 1, 0, 0, 1, 8'h42, 8'h42, 8'h00);   // zero, C=1
    endtask

    task automatic t_shift();
        run_op("R4", 2'b01, 0, 0, 0, 1, 8'h81, 8'h00, 8'h00);   // 0x40, C=1
        run_op("R5", 2'b01, 0, 1, 0, 1, 8'h02, 8'h00, 8'h00);   // C in -> 0x81, C=0
        run_op("R5", 2'b01, 0, 1, 0, 1, 8'h01, 8'h00, 8'h00);   // 0x00, Z=1, C=1
        run_op("R4", 2'b01, 0, 0, 0, 1, 8'hFE, 8'h00, 8'h00);   // 0x7F, C=0
    endtask

    task automatic t_flag_hold();
        run_op("R6", 2'b00, 0, 0, 0, 1, 8'hFF, 8'hFF, 8'h00);   // 0xFE, N=1 C=1
        run_op("R7", 2'b00, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);   // zero result, no write
        run_op("R7", 2'b01, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_mem_pass();
        run_op("R9",  2'b10, 0, 0, 0, 1, 8'h00, 8'h3C, 8'h00);  // load zero, flags keep
        run_op("R8",  2'b10, 0, 0, 1, 1, 8'h5A, 8'hC3, 8'h77);  // store strobe
        run_op("R10", 2'b11, 0, 0, 1, 1, 8'h00, 8'h12, 8'h99);  // pass zero, no strobe
        run_op("R1",  2'b11, 1, 1, 0, 1, 8'hA5, 8'h00, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_shift();
        t_flag_hold();
        t_mem_pass();
        report();
    end
endmodule